// File: doc/BRIEF.md
# Configurable SPI Bus Master

This block is the controlling end of a four-wire synchronous serial link. A host loads a transmit word, names the slave it wants, and picks the clock polarity, the clock phase, a clock divider, a word length of 1 to W bits and a wait between select assertion and the first clock edge. On a start pulse the block pulls the chosen active-low select line down. It waits the requested number of cycles and then runs one full-duplex exchange. Each bit goes out on MOSI while a bit from the slave is captured on MISO. At the end it presents the received word together with a one-cycle done pulse.

The four clock modes are numbered from the (polarity, phase) pair: 0 is (0,0), 1 is (0,1), 2 is (1,0) and 3 is (1,1). When the stream flag comes with a start, the select line stays low after that word. The host can then start the next word at once, with no new setup wait. The select line is released only after a word started with the stream flag clear. While any transfer or stream is in progress, the configuration inputs are ignored.

Top module: `spi_mst`

## Requirements
- R1: With phase 0, MISO is sampled on the first (leading) SCLK edge of each bit, which is the rising edge when polarity is 0 and the falling edge when polarity is 1. With phase 1, MISO is sampled on the trailing edge of each bit, which is falling for polarity 0 and rising for polarity 1. MOSI changes only on the edges that are not sampling edges, or at the load before the first edge.
- R2: Words are sent most significant bit first, starting from bit word_len-1 of tx_word. The first bit received lands in bit word_len-1 of rx_word and the last in bit 0. Bits of rx_word at or above word_len read 0.
- R3: word_len gives the number of bits per word, from 1 to W. A value of 0 or a value above W is taken as W. Each word produces exactly 2*word_len SCLK transitions.
- R4: ss_n bit k is low only while slave k (k = target) is being served, at most one bit of ss_n is low at any time, and all bits are high when the block is idle.
- R5: For a word that begins a new selection, the first SCLK transition comes exactly setup_wait + divider + 1 system clock cycles after ss_n falls.
- R6: Every SCLK half period lasts divider+1 system clock cycles. When no transfer is running, SCLK rests at the level of the polarity input, which it follows one cycle later.
- R7: done is a single-cycle pulse. It is raised on the clock edge that makes the last SCLK transition of a word, and rx_word is valid from that cycle on. For a word started without the stream flag, ss_n is released and busy falls divider+1 cycles after the done pulse.
- R8: After a word started with the stream flag set, ss_n stays low and busy stays high. A start in that state sends tx_word with no setup wait, and its first SCLK transition comes divider+1 cycles after the start cycle.
- R9: While busy is high, changes on polarity, phase, divider, word_len, target and setup_wait have no effect. A start that arrives during a word has no effect.
- R10: busy rises in the cycle after an accepted start and falls when the select line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a word (accepted when idle or holding a stream) |
| stream | input | 1 | Keep the select line low after this word |
| tx_word | input | W | Word to transmit, right-aligned |
| target | input | SEL_W | Index of the slave to select |
| cpol | input | 1 | Clock polarity (idle level of SCLK) |
| cpha | input | 1 | Clock phase (0: sample on leading edge, 1: on trailing edge) |
| divider | input | DIV_W | SCLK half period minus one, in system clocks |
| word_len | input | LEN_W | Bits per word |
| setup_wait | input | WAIT_W | Cycles between select assertion and the clock sequence |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | NSLV | Active-low select, one per slave |
| busy | output | 1 | High from an accepted start until the select release |
| done | output | 1 | One-cycle word-complete pulse |
| rx_word | output | W | Received word, right-aligned |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a word. The block has to ignore it, and also ignore a stray start arriving at the same time. The bench handles this by waiting until the bench's own slave model has seen the first SCLK transition. It then drives new values onto every configuration input and pulses start. After that it checks the transition count, the half-period lengths, the received word and the select index against the values that were latched. A second hard case is the stream continuation with no setup wait. The bench times its first SCLK edge from the start cycle, while counting select releases across the whole stream.

// File: rtl/spi_mst_pkg.sv
`timescale 1ns/1ps
package spi_mst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_TAIL,
        ST_HOLD
    } spi_st_e;

endpackage

// File: rtl/spi_mst_baud.sv
`timescale 1ns/1ps
module spi_mst_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // half-period counter never runs past the divider value (R6)
    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div));

endmodule

// File: rtl/spi_mst_shreg.sv
`timescale 1ns/1ps
module spi_mst_shreg #(
    parameter int W     = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     tx,
    input  logic [LEN_W-1:0] len,
    input  logic             sample,
    input  logic             drive,
    input  logic             miso,
    output logic             mosi,
    output logic [W-1:0]     rx_next
);
    typedef struct packed {
        logic [W-1:0] sr;
        logic         mosi;
    } sh_t;

    sh_t d, q;

    function automatic logic top_bit(input logic [W-1:0] v, input logic [LEN_W-1:0] n);
        logic b;
        b = 1'b0;
        for (int i = 0; i < W; i++)
            if (i == int'(n) - 1) b = v[i];
        return b;
    endfunction

    always_comb begin
        d = q;
        if (load) begin
            d.sr   = tx;
            d.mosi = top_bit(tx, len);
        end else begin
            if (sample) d.sr   = {q.sr[W-2:0], miso};
            if (drive)  d.mosi = top_bit(q.sr, len);
        end
        for (int i = 0; i < W; i++)
            rx_next[i] = d.sr[i] && (i < int'(len));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mosi = q.mosi;

    // MOSI must not move right after a sampling edge unless a new word loads (R1)
    assert_mosi_still_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sample) && !$past(load) && !$past(drive)) |-> $stable(q.mosi));

    // sampling and driving never share an edge (R1)
    assert_edge_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample && drive));

endmodule

// File: rtl/spi_mst.sv
`timescale 1ns/1ps
module spi_mst
    import spi_mst_pkg::*;
#(
    parameter int W      = 16,
    parameter int NSLV   = 4,
    parameter int DIV_W  = 8,
    parameter int WAIT_W = 8,
    localparam int LEN_W = $clog2(W + 1),
    localparam int SEL_W = (NSLV > 1) ? $clog2(NSLV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stream,
    input  logic [W-1:0]      tx_word,
    input  logic [SEL_W-1:0]  target,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  divider,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [WAIT_W-1:0] setup_wait,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [NSLV-1:0]   ss_n,
    output logic              busy,
    output logic              done,
    output logic [W-1:0]      rx_word
);
    localparam int EC_W = LEN_W + 1;

    typedef struct packed {
        spi_st_e           st;
        logic              cpol;
        logic              cpha;
        logic [DIV_W-1:0]  div;
        logic [LEN_W-1:0]  len;
        logic              strm;
        logic [WAIT_W-1:0] wcnt;
        logic [EC_W-1:0]   ec;
        logic              sclk;
        logic [NSLV-1:0]   ss_n;
        logic              busy;
        logic              done;
        logic [W-1:0]      rx;
    } ctl_t;

    ctl_t d, q;

    logic             tick, run, lead, xfer_tick;
    logic             sample, drive, load;
    logic [LEN_W-1:0] len_in, len_use;
    logic [W-1:0]     rx_next;
    logic [EC_W-1:0]  last_ec;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] n);
        return (n == '0 || int'(n) > W) ? LEN_W'(W) : n;
    endfunction

    function automatic logic [NSLV-1:0] sel_mask(input logic [SEL_W-1:0] t);
        logic [NSLV-1:0] m;
        for (int i = 0; i < NSLV; i++) m[i] = !(i == int'(t));
        return m;
    endfunction

    assign len_in    = clamp_len(word_len);
    assign len_use   = (q.st == ST_IDLE) ? len_in : q.len;
    assign run       = (q.st == ST_XFER) || (q.st == ST_TAIL);
    assign lead      = ~q.ec[0];
    assign xfer_tick = (q.st == ST_XFER) && tick;
    assign sample    = xfer_tick && (lead ^ q.cpha);
    assign drive     = xfer_tick && !(lead ^ q.cpha);
    assign load      = start && ((q.st == ST_IDLE) || (q.st == ST_HOLD));
    assign last_ec   = {q.len, 1'b0} - 1'b1;

    spi_mst_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (q.div),
        .tick (tick)
    );

    spi_mst_shreg #(.W(W), .LEN_W(LEN_W)) u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .tx     (tx_word),
        .len    (len_use),
        .sample (sample),
        .drive  (drive),
        .miso   (miso),
        .mosi   (mosi),
        .rx_next(rx_next)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.sclk = cpol;
                if (start) begin
                    d.cpol = cpol;
                    d.cpha = cpha;
                    d.div  = divider;
                    d.len  = len_in;
                    d.strm = stream;
                    d.ss_n = sel_mask(target);
                    d.busy = 1'b1;
                    d.ec   = '0;
                    d.wcnt = setup_wait - 1'b1;
                    d.st   = (setup_wait == '0) ? ST_XFER : ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (q.wcnt == '0) d.st = ST_XFER;
                else              d.wcnt = q.wcnt - 1'b1;
            end
            ST_XFER: begin
                if (tick) begin
                    d.sclk = ~q.sclk;
                    if (q.ec == last_ec) begin
                        d.done = 1'b1;
                        d.rx   = rx_next;
                        d.st   = q.strm ? ST_HOLD : ST_TAIL;
                    end else begin
                        d.ec = q.ec + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    d.st   = ST_IDLE;
                    d.ss_n = '1;
                    d.busy = 1'b0;
                end
            end
            ST_HOLD: begin
                if (start) begin
                    d.strm = stream;
                    d.ec   = '0;
                    d.st   = ST_XFER;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ss_n <= '1;
        end else begin
            q <= d;
        end
    end

    assign sclk    = q.sclk;
    assign ss_n    = q.ss_n;
    assign busy    = q.busy;
    assign done    = q.done;
    assign rx_word = q.rx;

    // at most one slave selected (R4)
    assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~q.ss_n) <= 1);

    // idle means nobody selected (R4)
    assert_idle_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> (&q.ss_n));

    // during the setup wait SCLK rests at the latched polarity (R6)
    assert_sclk_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SETUP) |-> (q.sclk == q.cpol));

    // SCLK moves only on a divider tick once a transfer is under way (R6)
    assert_sclk_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st != ST_IDLE) && !tick) |=> $stable(q.sclk));

    // done lasts one cycle (R7)
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // select pattern frozen while busy, whatever the inputs do (R9)
    assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> $stable(q.ss_n));

    // holding a stream keeps select asserted (R8)
    assert_hold_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD) |-> (q.busy && !(&q.ss_n)));

endmodule

// File: tb/spi_mst_tb.sv
`timescale 1ns/1ps
module spi_mst_tb;
    localparam int PERIOD = 10;
    localparam int NV     = 10;

    // {mode[1:0], len[4:0], div[3:0], wait[3:0], tx[15:0], slave_tx[15:0], target[1:0]}
    localparam logic [48:0] VEC [NV] = '{
        {2'd0, 5'd8,  4'd1, 4'd2, 16'h00A5, 16'h003C, 2'd0},
        {2'd1, 5'd8,  4'd0, 4'd0, 16'h005A, 16'h00C3, 2'd1},
        {2'd2, 5'd12, 4'd2, 4'd1, 16'h0ABC, 16'h0531, 2'd2},
        {2'd3, 5'd16, 4'd3, 4'd5, 16'hBEEF, 16'h1234, 2'd3},
        {2'd0, 5'd1,  4'd0, 4'd0, 16'h0001, 16'h0001, 2'd0},
        {2'd3, 5'd5,  4'd4, 4'd3, 16'h0015, 16'h000A, 2'd1},
        {2'd1, 5'd16, 4'd0, 4'd7, 16'hFFFF, 16'h0000, 2'd2},
        {2'd2, 5'd0,  4'd1, 4'd0, 16'h1234, 16'hABCD, 2'd3},
        {2'd0, 5'd20, 4'd0, 4'd1, 16'h8001, 16'h7FFE, 2'd0},
        {2'd3, 5'd3,  4'd2, 4'd0, 16'hFFF5, 16'hFFFA, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, stream = 1'b0;
    logic [15:0] tx_word = '0;
    logic [1:0]  target = '0;
    logic        cpol = 1'b0, cpha = 1'b0;
    logic [7:0]  divider = '0;
    logic [4:0]  word_len = 5'd8;
    logic [7:0]  setup_wait = '0;
    logic        miso = 1'b0;
    logic        sclk, mosi, busy, done;
    logic [3:0]  ss_n;
    logic [15:0] rx_word;

    int errors = 0;
    int checks = 0;

    spi_mst u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stream(stream),
        .tx_word(tx_word), .target(target), .cpol(cpol), .cpha(cpha),
        .divider(divider), .word_len(word_len), .setup_wait(setup_wait),
        .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
        .busy(busy), .done(done), .rx_word(rx_word)
    );

    always #(PERIOD/2) clk = ~clk;

    // slave model and line monitors
    logic        m_cpol = 1'b0, m_cpha = 1'b0;
    logic [15:0] s_tx = '0, s_rx = '0;
    int          s_len = 8, s_cnt = 0, edges = 0, half_bad = 0;
    int          fall_cnt = 0, rise_cnt = 0, done_cnt = 0;
    time         half = PERIOD, t_first = 0, t_last = 0;
    time         t_ssfall = 0, t_ssrise = 0, t_done = 0, t_start = 0;
    logic [3:0]  ss_prev = 4'hF;

    always @(sclk) begin
        if (ss_n != 4'hF) begin
            edges++;
            if (edges == 1) t_first = $time;
            else if ($time - t_last != half) half_bad++;
            t_last = $time;
            if ((sclk == 1'b1) == !(m_cpol ^ m_cpha)) begin
                s_rx = {s_rx[14:0], mosi};
                s_cnt++;
            end else if (s_cnt < s_len) begin
                miso = s_tx[s_len-1-s_cnt];
            end
        end
    end

    always @(ss_n) begin
        if (ss_n != 4'hF && ss_prev == 4'hF) begin t_ssfall = $time; fall_cnt++; end
        if (ss_n == 4'hF && ss_prev != 4'hF) begin t_ssrise = $time; rise_cnt++; end
        ss_prev = ss_n;
    end

    always @(posedge done) begin
        t_done = $time;
        done_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic run_word(input logic [1:0] mode, input logic [4:0] len,
                            input logic [7:0] dv, input logic [7:0] wt,
                            input logic [15:0] tx, input logic [15:0] stx,
                            input logic [1:0] tgt, input bit strm, input bit cont);
        int          el;
        logic [15:0] mask;
        bit          seen;
        el   = (len == 0 || len > 16) ? 16 : int'(len);
        mask = (el == 16) ? 16'hFFFF : ((16'h1 << el) - 16'h1);
        @(negedge clk);
        cpol = mode[1]; cpha = mode[0]; divider = dv; word_len = len;
        setup_wait = wt; tx_word = tx; target = tgt; stream = strm;
        m_cpol = mode[1]; m_cpha = mode[0]; half = (dv + 1) * PERIOD;
        s_tx = stx; s_len = el; s_cnt = 0; s_rx = '0; edges = 0; half_bad = 0;
        miso = stx[el-1];
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        t_start = $time;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", busy, 1);
        wait_done(seen);
        chk(seen, "R7", "done pulse seen", seen, 1);
        chk(rx_word == (stx & mask), "R2", "received word", rx_word, stx & mask);
        chk((s_rx & mask) == (tx & mask), "R2", "slave got word", s_rx & mask, tx & mask);
        chk(edges == 2 * el, "R3", "sclk transitions", edges, 2 * el);
        chk(half_bad == 0, "R6", "bad half periods", half_bad, 0);
        chk(ss_n == ~(4'b1 << tgt), "R4", "select pattern", ss_n, ~(4'b1 << tgt));
        if (cont)
            chk(t_first - t_start == (dv + 1) * PERIOD, "R8", "continuation first edge",
                t_first - t_start, (dv + 1) * PERIOD);
        else
            chk(t_first - t_ssfall == (wt + dv + 1) * PERIOD, "R5", "setup to first edge",
                t_first - t_ssfall, (wt + dv + 1) * PERIOD);
        if (!strm) begin
            for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
            chk(t_ssrise - t_done == (dv + 1) * PERIOD, "R7", "release after done",
                t_ssrise - t_done, (dv + 1) * PERIOD);
            chk(ss_n == 4'hF && !busy, "R4", "deselect at end", {busy, ss_n}, 5'h0F);
        end else begin
            repeat (3) @(negedge clk);
            chk(ss_n == ~(4'b1 << tgt) && busy, "R8", "select held in stream",
                {busy, ss_n}, {1'b1, ~(4'b1 << tgt)});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [48:0] v;
        int          rc, dc;
        bit          seen;

        // reset state
        repeat (3) @(negedge clk);
        chk(ss_n == 4'hF, "R4", "reset select", ss_n, 4'hF);
        chk(!busy && !done, "R10", "reset busy/done", {busy, done}, 0);
        chk(sclk == 1'b0, "R6", "reset sclk", sclk, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(rx_word == 16'h0, "R2", "reset rx", rx_word, 0);

        // idle SCLK follows polarity
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R6", "idle level cpol=1", sclk, 1);
        cpol = 1'b0;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R6", "idle level cpol=0", sclk, 0);

        // vector table: all modes, lengths, dividers, waits (R1, R2, R3, R5)
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            run_word(v[48:47], v[46:42], {4'd0, v[41:38]}, {4'd0, v[37:34]},
                     v[33:18], v[17:2], v[1:0], 1'b0, 1'b0);
            repeat (2) @(negedge clk);
        end

        // stream of three words, select held throughout (R8)
        rc = rise_cnt;
        dc = done_cnt;
        run_word(2'd1, 5'd8, 8'd1, 8'd3, 16'h00C9, 16'h0071, 2'd2, 1'b1, 1'b0);
        run_word(2'd1, 5'd8, 8'd1, 8'd3, 16'h0036, 16'h008E, 2'd2, 1'b1, 1'b1);
        run_word(2'd1, 5'd8, 8'd1, 8'd3, 16'h00F0, 16'h000F, 2'd2, 1'b0, 1'b1);
        chk(rise_cnt - rc == 1, "R8", "single release over stream", rise_cnt - rc, 1);
        chk(done_cnt - dc == 3, "R8", "done pulses in stream", done_cnt - dc, 3);

        // mid-word configuration changes and a stray start are ignored (R9)
        repeat (2) @(negedge clk);
        dc = done_cnt;
        @(negedge clk);
        cpol = 1'b0; cpha = 1'b0; divider = 8'd2; word_len = 5'd8; setup_wait = 8'd1;
        tx_word = 16'h00B4; target = 2'd1; stream = 1'b0;
        m_cpol = 1'b0; m_cpha = 1'b0; half = 3 * PERIOD;
        s_tx = 16'h0069; s_len = 8; s_cnt = 0; s_rx = '0; edges = 0; half_bad = 0;
        miso = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 100 && edges == 0; k++) @(negedge clk);
        cpol = 1'b1; cpha = 1'b1; divider = 8'd0; word_len = 5'd4; setup_wait = 8'd0;
        target = 2'd3; tx_word = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk(seen, "R9", "done after ignored changes", seen, 1);
        chk(rx_word == 16'h0069, "R9", "rx with latched config", rx_word, 16'h0069);
        chk(s_rx[7:0] == 8'hB4, "R9", "tx with latched word", s_rx[7:0], 8'hB4);
        chk(edges == 16, "R9", "latched length kept", edges, 16);
        chk(half_bad == 0, "R9", "latched divider kept", half_bad, 0);
        chk(ss_n == 4'b1101, "R9", "latched target kept", ss_n, 4'b1101);
        for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(done_cnt - dc == 1 && !busy, "R9", "stray start ignored",
            done_cnt - dc, 1);

        summary();
        $finish;
    end
endmodule